// File: doc/BRIEF.md
# Banked Data Memory Address Unit

This block turns the operand fields of an 8-bit controller's data-memory instructions into 12-bit data addresses, and it stands in front of the banked static RAM. A bank register supplies the upper four address bits for banked accesses. A one-bit flag in each direct access can set that register aside and select a split window instead. The window joins the lower half of bank 0 to the upper half of bank 15, so the special function registers can always be reached with no bank switch.

The data space is 4 KiB, divided into sixteen 256-byte banks. A parameter bitmask chooses which banks hold general-purpose RAM. Only those banks take up storage, packed one after another. Addresses F80h–FFFh go out on a separate SFR port with read and write strobes. Every other address reads as 00h and ignores writes.

An absolute memory-to-memory move takes full 12-bit source and destination addresses and does not use the bank register. It takes two cycles: the first reads the source, and the second writes the captured byte to the destination.

Top module: `dmau_top`

## Requirements
- R1: A direct access with `bank_mode_i`=1 resolves to address {bank register[3:0], `file_i`}.
- R2: A direct access with `bank_mode_i`=0 and `file_i` in 00h–7Fh resolves to 000h–07Fh, whatever the bank register holds.
- R3: A direct access with `bank_mode_i`=0 and `file_i` in 80h–FFh resolves to F80h–FFFh. Any address in F80h–FFFh is served by the SFR port at offset `addr[6:0]`: `sfr_we_o` is raised for writes, `sfr_re_o` for reads, and `rdata_o` returns `sfr_rdata_i`.
- R4: Operation code 3 (set-bank) loads `bank_lit_i[3:0]` into the bank register. `bank_o[7:4]` always reads 0.
- R5: A synchronous reset clears the bank register to 00h and returns the move sequencer to idle.
- R6: An address in a bank that is not implemented reads as 00h, and a write to it changes no storage. This includes F00h–F7Fh and any GPR bank whose bit in `GPR_MASK` is clear.
- R7: Operation code 4 (move) reads `src_abs_i` in its first cycle, with `busy_o`=0. In the second cycle `busy_o`=1, `addr_o`=`dst_abs_i` as captured in the first cycle, and the captured byte is written there. The bank register takes no part.
- R8: Writes (operation code 2) take effect at the rising clock edge. Reads (operation code 1) are combinational from the resolved address in the same cycle.
- R9: While `busy_o`=1, `op_i` is ignored. A set-bank issued then leaves the bank register unchanged.
- R10: Each implemented GPR bank has its own storage. A write to one bank does not change the same offset in another implemented bank.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_i | input | 3 | 0 idle, 1 read, 2 write, 3 set-bank, 4 move |
| bank_mode_i | input | 1 | 1 = use bank register, 0 = split access window |
| file_i | input | 8 | Offset field of a direct access |
| wdata_i | input | 8 | Write data of a direct write |
| bank_lit_i | input | 8 | Literal for set-bank |
| src_abs_i | input | 12 | Move source address |
| dst_abs_i | input | 12 | Move destination address |
| rdata_o | output | 8 | Read data at the resolved address |
| addr_o | output | 12 | Resolved address |
| bank_o | output | 8 | Bank register read-back |
| busy_o | output | 1 | Move destination cycle in progress |
| sfr_addr_o | output | 7 | SFR offset |
| sfr_we_o | output | 1 | SFR write strobe |
| sfr_re_o | output | 1 | SFR read strobe |
| sfr_wdata_o | output | 8 | SFR write data |
| sfr_rdata_i | input | 8 | SFR read data |

## Verification
The bench builds the block with `GPR_MASK` = 16'h0023, which implements banks 0, 1 and 5 and packs them into 768 bytes. With that setting the bench can check that a gap bank (2) and the lower half of bank 15 read as zero and ignore writes. It can also check that two implemented banks at the same offset do not alias, and that a move crosses from one bank to another while the bank register points at an empty bank. A small register model on the SFR port confirms that the access window and the banked path through bank 15 reach the same SFR.

// File: rtl/dmau_pkg.sv
package dmau_pkg;

    localparam int ADDR_W    = 12;
    localparam int DATA_W    = 8;
    localparam int OFF_W     = 8;
    localparam int BANK_W    = 4;
    localparam int NUM_BANKS = 1 << BANK_W;
    localparam int BANK_SIZE = 1 << OFF_W;
    localparam int SFR_W     = OFF_W - 1;

    typedef logic [ADDR_W-1:0] addr_t;
    typedef logic [DATA_W-1:0] byte_t;

    typedef enum logic [2:0] {
        OP_IDLE    = 3'd0,
        OP_READ    = 3'd1,
        OP_WRITE   = 3'd2,
        OP_SETBANK = 3'd3,
        OP_MOVE    = 3'd4
    } op_e;

    typedef enum logic {
        MV_IDLE = 1'b0,
        MV_DST  = 1'b1
    } mv_state_e;

    typedef struct packed {
        logic              sfr_hit;
        logic              gpr_hit;
        logic [SFR_W-1:0]  sfr_off;
    } region_t;

    // split window: low half of offsets -> bank 0, high half -> top of last bank
    function automatic addr_t resolve_direct(input logic banked,
                                             input logic [BANK_W-1:0] bank,
                                             input logic [OFF_W-1:0] off);
        if (banked)
            return {bank, off};
        else if (off[OFF_W-1])
            return {{BANK_W{1'b1}}, off};
        else
            return {{BANK_W{1'b0}}, off};
    endfunction

    function automatic logic in_sfr(input addr_t a);
        return a[ADDR_W-1:SFR_W] == '1;
    endfunction

    function automatic int popcount16(input logic [NUM_BANKS-1:0] m);
        int n;
        n = 0;
        for (int i = 0; i < NUM_BANKS; i++) n += int'(m[i]);
        return n;
    endfunction

    function automatic int bank_rank(input logic [NUM_BANKS-1:0] m,
                                     input logic [BANK_W-1:0] b);
        int n;
        n = 0;
        for (int i = 0; i < NUM_BANKS; i++)
            if (i < int'(b)) n += int'(m[i]);
        return n;
    endfunction

endpackage

// File: rtl/dmau_bank_reg.sv
module dmau_bank_reg
    import dmau_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  byte_t             lit,
    output logic [BANK_W-1:0] bank,
    output byte_t             bank_rd
);
    logic [BANK_W-1:0] bank_q;

    always_ff @(posedge clk) begin
        if (rst)
            bank_q <= '0;
        else if (load)
            bank_q <= lit[BANK_W-1:0];
    end

    assign bank    = bank_q;
    assign bank_rd = {{(DATA_W-BANK_W){1'b0}}, bank_q};
endmodule

// File: rtl/dmau_move_seq.sv
module dmau_move_seq
    import dmau_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  start,
    input  byte_t src_data,
    input  addr_t dst_abs,
    output logic  busy,
    output addr_t dst_q,
    output byte_t hold_q
);
    mv_state_e state_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= MV_IDLE;
            dst_q   <= '0;
            hold_q  <= '0;
        end else begin
            case (state_q)
                MV_IDLE: if (start) begin
                    state_q <= MV_DST;
                    dst_q   <= dst_abs;
                    hold_q  <= src_data;
                end
                default: state_q <= MV_IDLE;
            endcase
        end
    end

    assign busy = (state_q == MV_DST);
endmodule

// File: rtl/dmau_addr_gen.sv
module dmau_addr_gen
    import dmau_pkg::*;
(
    input  logic              busy,
    input  op_e               op,
    input  logic              banked,
    input  logic [BANK_W-1:0] bank,
    input  logic [OFF_W-1:0]  file_off,
    input  addr_t             src_abs,
    input  addr_t             dst_q,
    output addr_t             addr
);
    always_comb begin
        if (busy)
            addr = dst_q;
        else if (op == OP_MOVE)
            addr = src_abs;
        else
            addr = resolve_direct(banked, bank, file_off);
    end
endmodule

// File: rtl/dmau_mem_router.sv
module dmau_mem_router
    import dmau_pkg::*;
#(
    parameter logic [15:0] GPR_MASK = 16'h0001
) (
    input  logic             clk,
    input  addr_t            addr,
    input  logic             we,
    input  logic             re,
    input  byte_t            wdata,
    output byte_t            rdata,
    output logic [SFR_W-1:0] sfr_addr,
    output logic             sfr_we,
    output logic             sfr_re,
    output byte_t            sfr_wdata,
    input  byte_t            sfr_rdata
);
    // the SFR bank never holds GPR storage
    localparam logic [NUM_BANKS-1:0] EFF_MASK = GPR_MASK & 16'h7FFF;
    localparam int NUM_GPR   = popcount16(EFF_MASK);
    localparam int RAM_DEPTH = ((NUM_GPR > 0) ? NUM_GPR : 1) * BANK_SIZE;
    localparam int IDX_W     = $clog2(RAM_DEPTH);

    byte_t             mem [RAM_DEPTH];
    region_t           reg_s;
    logic [IDX_W-1:0]  idx;

    always_comb begin
        reg_s.sfr_hit = in_sfr(addr);
        reg_s.gpr_hit = EFF_MASK[addr[ADDR_W-1:OFF_W]] && !reg_s.sfr_hit;
        reg_s.sfr_off = addr[SFR_W-1:0];
        idx = IDX_W'(bank_rank(EFF_MASK, addr[ADDR_W-1:OFF_W]) * BANK_SIZE
                     + int'(addr[OFF_W-1:0]));
    end

    always_ff @(posedge clk) begin
        if (we && reg_s.gpr_hit)
            mem[idx] <= wdata;
    end

    always_comb begin
        if (reg_s.sfr_hit)
            rdata = sfr_rdata;
        else if (reg_s.gpr_hit)
            rdata = mem[idx];
        else
            rdata = '0;
    end

    assign sfr_addr  = reg_s.sfr_off;
    assign sfr_we    = we && reg_s.sfr_hit;
    assign sfr_re    = re && reg_s.sfr_hit;
    assign sfr_wdata = wdata;
endmodule

// File: rtl/dmau_top.sv
module dmau_top
    import dmau_pkg::*;
#(
    parameter logic [15:0] GPR_MASK = 16'h0001
) (
    input  logic        clk,
    input  logic        rst,
    input  logic [2:0]  op_i,
    input  logic        bank_mode_i,
    input  logic [7:0]  file_i,
    input  logic [7:0]  wdata_i,
    input  logic [7:0]  bank_lit_i,
    input  logic [11:0] src_abs_i,
    input  logic [11:0] dst_abs_i,
    output logic [7:0]  rdata_o,
    output logic [11:0] addr_o,
    output logic [7:0]  bank_o,
    output logic        busy_o,
    output logic [6:0]  sfr_addr_o,
    output logic        sfr_we_o,
    output logic        sfr_re_o,
    output logic [7:0]  sfr_wdata_o,
    input  logic [7:0]  sfr_rdata_i
);
    op_e               op;
    logic              busy;
    logic [BANK_W-1:0] bank;
    addr_t             addr, dst_q;
    byte_t             hold_q, rdata, wdata;
    logic              we, re;

    assign op = op_e'(op_i);

    dmau_bank_reg u_bank (
        .clk     (clk),
        .rst     (rst),
        .load    (!busy && op == OP_SETBANK),
        .lit     (bank_lit_i),
        .bank    (bank),
        .bank_rd (bank_o)
    );

    dmau_move_seq u_move (
        .clk      (clk),
        .rst      (rst),
        .start    (!busy && op == OP_MOVE),
        .src_data (rdata),
        .dst_abs  (dst_abs_i),
        .busy     (busy),
        .dst_q    (dst_q),
        .hold_q   (hold_q)
    );

    dmau_addr_gen u_agen (
        .busy     (busy),
        .op       (op),
        .banked   (bank_mode_i),
        .bank     (bank),
        .file_off (file_i),
        .src_abs  (src_abs_i),
        .dst_q    (dst_q),
        .addr     (addr)
    );

    assign we    = busy || (op == OP_WRITE);
    assign re    = !busy && (op == OP_READ || op == OP_MOVE);
    assign wdata = busy ? hold_q : wdata_i;

    dmau_mem_router #(.GPR_MASK(GPR_MASK)) u_route (
        .clk       (clk),
        .addr      (addr),
        .we        (we),
        .re        (re),
        .wdata     (wdata),
        .rdata     (rdata),
        .sfr_addr  (sfr_addr_o),
        .sfr_we    (sfr_we_o),
        .sfr_re    (sfr_re_o),
        .sfr_wdata (sfr_wdata_o),
        .sfr_rdata (sfr_rdata_i)
    );

    assign rdata_o = rdata;
    assign addr_o  = addr;
    assign busy_o  = busy;
endmodule

// File: rtl/dmau_checker.sv
module dmau_checker #(
    parameter logic [15:0] GPR_MASK = 16'h0001
) (
    input logic        clk,
    input logic        rst,
    input logic [2:0]  op_i,
    input logic        bank_mode_i,
    input logic [7:0]  file_i,
    input logic [11:0] dst_abs_i,
    input logic [7:0]  rdata_o,
    input logic [11:0] addr_o,
    input logic [7:0]  bank_o,
    input logic        busy_o,
    input logic        sfr_we_o,
    input logic        sfr_re_o
);
    localparam logic [15:0] EFF = GPR_MASK & 16'h7FFF;

    p_bank_hi_zero_r4: assert property (@(posedge clk) disable iff (rst)
        bank_o[7:4] == 4'h0);

    p_banked_addr_r1: assert property (@(posedge clk) disable iff (rst)
        (!busy_o && op_i == 3'd1 && bank_mode_i) |-> addr_o == {bank_o[3:0], file_i});

    p_sfr_strobe_range_r3: assert property (@(posedge clk) disable iff (rst)
        (sfr_we_o || sfr_re_o) |-> addr_o[11:7] == 5'h1F);

    p_unimpl_zero_r6: assert property (@(posedge clk) disable iff (rst)
        (!EFF[addr_o[11:8]] && addr_o[11:7] != 5'h1F) |-> rdata_o == 8'h00);

    p_move_enters_r7: assert property (@(posedge clk) disable iff (rst)
        (!busy_o && op_i == 3'd4) |=> (busy_o && addr_o == $past(dst_abs_i)));

    p_busy_single_r7: assert property (@(posedge clk) disable iff (rst)
        busy_o |=> !busy_o);

    p_bank_hold_r9: assert property (@(posedge clk) disable iff (rst)
        busy_o |=> $stable(bank_o));
endmodule

bind dmau_top dmau_checker #(.GPR_MASK(GPR_MASK)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .op_i        (op_i),
    .bank_mode_i (bank_mode_i),
    .file_i      (file_i),
    .dst_abs_i   (dst_abs_i),
    .rdata_o     (rdata_o),
    .addr_o      (addr_o),
    .bank_o      (bank_o),
    .busy_o      (busy_o),
    .sfr_we_o    (sfr_we_o),
    .sfr_re_o    (sfr_re_o)
);

// File: tb/dmau_top_tb_top.sv
`timescale 1ns/1ps
module dmau_top_tb_top;
    logic        clk = 1'b0;
    logic        rst;
    logic [2:0]  op_i;
    logic        bank_mode_i;
    logic [7:0]  file_i, wdata_i, bank_lit_i;
    logic [11:0] src_abs_i, dst_abs_i;
    logic [7:0]  rdata_o, bank_o, sfr_wdata_o, sfr_rdata_i;
    logic [11:0] addr_o;
    logic        busy_o, sfr_we_o, sfr_re_o;
    logic [6:0]  sfr_addr_o;

    logic [7:0] sfr_mem [128];
    int n_chk = 0, n_fail = 0;
    bit done = 0;
    int sfr_we_seen = 0;

    always #2.5 clk = ~clk;

    dmau_top #(.GPR_MASK(16'h0023)) dut_i (.*);

    always @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < 128; i++) sfr_mem[i] <= 8'h00;
        end else if (sfr_we_o) begin
            sfr_mem[sfr_addr_o] <= sfr_wdata_o;
            sfr_we_seen <= sfr_we_seen + 1;
        end
    end
    assign sfr_rdata_i = sfr_mem[sfr_addr_o];

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic cyc();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic idle();
        op_i = 3'd0; bank_mode_i = 1'b1; file_i = 8'h00; wdata_i = 8'h00;
        bank_lit_i = 8'h00; src_abs_i = '0; dst_abs_i = '0;
    endtask

    task automatic set_bank(input logic [7:0] lit);
        op_i = 3'd3; bank_lit_i = lit; cyc(); idle();
    endtask

    task automatic wr(input logic a, input logic [7:0] f, input logic [7:0] d);
        op_i = 3'd2; bank_mode_i = a; file_i = f; wdata_i = d; cyc(); idle();
    endtask

    task automatic rd(input logic a, input logic [7:0] f, output logic [11:0] ad,
                      output logic [7:0] d);
        op_i = 3'd1; bank_mode_i = a; file_i = f; #1;
        ad = addr_o; d = rdata_o; cyc(); idle();
    endtask

    task automatic t_reset();
        chk("R5 bank after reset", bank_o, 8'h00);
        chk("R5 busy after reset", busy_o, 0);
    endtask

    task automatic t_setbank();
        set_bank(8'hA5);
        chk("R4 set-bank low nibble", bank_o, 8'h05);
        set_bank(8'hFF);
        chk("R4 upper bits read zero", bank_o, 8'h0F);
    endtask

    task automatic t_banked();
        logic [11:0] a; logic [7:0] d;
        set_bank(8'h01);
        wr(1'b1, 8'h10, 8'h3C);
        rd(1'b1, 8'h10, a, d);
        chk("R1 banked address", a, 12'h110);
        chk("R8 read after write", d, 8'h3C);
        set_bank(8'h05);
        wr(1'b1, 8'h10, 8'h77);
        rd(1'b1, 8'h10, a, d);
        chk("R1 bank5 address", a, 12'h510);
        chk("R10 bank5 data", d, 8'h77);
        set_bank(8'h01);
        rd(1'b1, 8'h10, a, d);
        chk("R10 bank1 not aliased", d, 8'h3C);
    endtask

    task automatic t_access_low();
        logic [11:0] a; logic [7:0] d;
        set_bank(8'h05);
        wr(1'b0, 8'h10, 8'h99);
        rd(1'b0, 8'h7F, a, d);
        chk("R2 last low offset", a, 12'h07F);
        set_bank(8'h00);
        rd(1'b1, 8'h10, a, d);
        chk("R2 access write landed in bank0", d, 8'h99);
        set_bank(8'h05);
        rd(1'b1, 8'h10, a, d);
        chk("R2 bank5 untouched", d, 8'h77);
        rd(1'b0, 8'h80, a, d);
        chk("R3 first high offset", a, 12'hF80);
    endtask

    task automatic t_sfr();
        logic [11:0] a; logic [7:0] d; int seen0;
        set_bank(8'h01);
        seen0 = sfr_we_seen;
        wr(1'b0, 8'h85, 8'h5A);
        chk("R3 SFR write strobe", sfr_we_seen - seen0, 1);
        chk("R3 SFR model offset 5", sfr_mem[5], 8'h5A);
        op_i = 3'd1; bank_mode_i = 1'b0; file_i = 8'h85; #1;
        chk("R3 SFR read strobe", sfr_re_o, 1);
        chk("R3 SFR read offset", sfr_addr_o, 7'h05);
        chk("R3 SFR read data", rdata_o, 8'h5A);
        cyc(); idle();
        set_bank(8'h0F);
        rd(1'b1, 8'h85, a, d);
        chk("R3 banked path to same SFR", d, 8'h5A);
    endtask

    task automatic t_unimpl();
        logic [11:0] a; logic [7:0] d;
        set_bank(8'h00);
        wr(1'b1, 8'h20, 8'h11);
        set_bank(8'h02);
        wr(1'b1, 8'h20, 8'hEE);
        rd(1'b1, 8'h20, a, d);
        chk("R6 gap bank reads zero", d, 8'h00);
        set_bank(8'h00);
        rd(1'b1, 8'h20, a, d);
        chk("R6 gap write left bank0", d, 8'h11);
        set_bank(8'h0F);
        wr(1'b1, 8'h20, 8'hAB);
        rd(1'b1, 8'h20, a, d);
        chk("R6 bank15 low half zero", d, 8'h00);
    endtask

    task automatic t_move();
        logic [11:0] a; logic [7:0] d;
        set_bank(8'h00);
        wr(1'b1, 8'h40, 8'hC3);
        set_bank(8'h02);
        op_i = 3'd4; src_abs_i = 12'h040; dst_abs_i = 12'h155; #1;
        chk("R7 move cycle1 not busy", busy_o, 0);
        chk("R7 move source addr", addr_o, 12'h040);
        chk("R7 move source data", rdata_o, 8'hC3);
        cyc();
        op_i = 3'd3; bank_lit_i = 8'h07; dst_abs_i = 12'h000; #1;
        chk("R7 move cycle2 busy", busy_o, 1);
        chk("R7 move dest addr", addr_o, 12'h155);
        cyc(); idle();
        chk("R9 set-bank ignored while busy", bank_o, 8'h02);
        chk("R7 busy cleared", busy_o, 0);
        set_bank(8'h01);
        rd(1'b1, 8'h55, a, d);
        chk("R7 moved byte at destination", d, 8'hC3);
        op_i = 3'd4; src_abs_i = 12'hF85; dst_abs_i = 12'h5EE; cyc(); cyc(); idle();
        set_bank(8'h05);
        rd(1'b1, 8'hEE, a, d);
        chk("R7 SFR-to-GPR move", d, 8'h5A);
    endtask

    initial begin
        idle();
        rst = 1'b1;
        repeat (3) cyc();
        rst = 1'b0;
        cyc();
        t_reset();
        t_setbank();
        t_banked();
        t_access_low();
        t_sfr();
        t_unimpl();
        t_move();
        rst = 1'b1; cyc(); rst = 1'b0; cyc();
        chk("R5 bank after second reset", bank_o, 8'h00);
        if (!done) begin
            done = 1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule